// File: doc/BRIEF.md
# Baseband Slot Clock and Task Timer

This block keeps time for a frequency-hopping baseband. A fine phase counter, stepped from a 12 MHz tick enable, measures the position inside the current half slot. Each time it wraps, a free-running native half-slot counter advances. Adding a programmable slot offset and phase offset to this pair gives a master clock, so a device can follow a remote master's timing without disturbing its own free-running count.

Two one-shot task timers, one for transmit and one for receive, each hold a target slot and a target phase. When an armed timer sees the master clock equal its target, it issues a single-cycle start strobe, disarms itself and raises a sticky interrupt flag. Firmware programs the offsets and targets through a small write port. A prescaler stretches the phase step for low-power operation. Strobes mark the native and master half-slot boundaries.

Top module: `bt_slot_timer`

## Requirements
- R1: After reset the phase, native slot, both offsets, both task targets, both enables and both interrupt flags are zero, and the start and boundary strobes are low.
- R2: With presc = P, the phase counter advances once for every P+1 cycles in which tick_en is high. When tick_en is low, neither phase nor native_slot changes, and phase never exceeds PHASE_LAST.
- R3: An advance from phase PHASE_LAST gives phase 0 and increments native_slot modulo 2^SLOT_W. half_slot_strobe is high in the cycle whose clock edge performs that wrap.
- R4: master_phase = (phase + phase offset) mod (PHASE_LAST+1). master_slot = native_slot + slot offset + carry modulo 2^SLOT_W, where carry is 1 when the phase sum exceeds PHASE_LAST.
- R5: Write address 0 loads the slot offset from wr_data[SLOT_W-1:0]. Address 1 loads the phase offset, and a value greater than PHASE_LAST written there is ignored.
- R6: master_strobe is high in a cycle where the phase advances while master_phase equals PHASE_LAST.
- R7: Address 2 (task 0) and address 4 (task 1) load a target slot. Address 3 and address 5 load a target phase from bits [PHASE_W-1:0] and an enable from bit 31. In the cycle after an enabled task sees master_slot and master_phase equal its targets, a one-cycle start pulse appears: tx_start for task 0, rx_start for task 1.
- R8: When a task fires, its enable clears and its interrupt flag sets at the same edge that raises its start pulse. The flag then stays set without further firing.
- R9: A write to address 6 clears interrupt flag i for each wr_data bit i (i = 0, 1) that is 1. A firing in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 12 MHz phase tick enable |
| presc | input | PRE_W | Phase prescaler, P+1 ticks per step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| phase | output | PHASE_W | Native phase inside half slot |
| native_slot | output | SLOT_W | Free-running half-slot count |
| master_phase | output | PHASE_W | Adjusted phase |
| master_slot | output | SLOT_W | Adjusted half-slot count |
| half_slot_strobe | output | 1 | Native boundary strobe |
| master_strobe | output | 1 | Master boundary strobe |
| tx_start | output | 1 | Task 0 start pulse |
| rx_start | output | 1 | Task 1 start pulse |
| task_en | output | 2 | Task armed flags |
| task_irq | output | 2 | Sticky task interrupt flags |

## Verification
The bench builds the block with SLOT_W = 8 and PHASE_LAST = 99. A half slot then lasts 100 ticks, and a full native-slot wraparound takes 25,600 ticks. This brings the native slot wrap and the modulo behaviour of the master slot within a short run. These values also let the bench place the carry from the phase offset, the master boundary and both task firings at phase values it can compute by hand.

// File: rtl/bt_slot_timer.sv
module bt_slot_timer #(
  parameter int SLOT_W     = 28,
  parameter int PHASE_W    = 12,
  parameter int PHASE_LAST = 3749,
  parameter int PRE_W      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic [PRE_W-1:0]   presc,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [31:0]        wr_data,
  output logic [PHASE_W-1:0] phase,
  output logic [SLOT_W-1:0]  native_slot,
  output logic [PHASE_W-1:0] master_phase,
  output logic [SLOT_W-1:0]  master_slot,
  output logic               half_slot_strobe,
  output logic               master_strobe,
  output logic               tx_start,
  output logic               rx_start,
  output logic [1:0]         task_en,
  output logic [1:0]         task_irq
);

  localparam logic [PHASE_W:0]   PH_MOD  = (PHASE_W+1)'(PHASE_LAST + 1);
  localparam logic [PHASE_W-1:0] PH_LAST = PHASE_W'(PHASE_LAST);

  logic [PRE_W-1:0]   pre_cnt;
  logic [SLOT_W-1:0]  off_slot;
  logic [PHASE_W-1:0] off_ph;
  logic [SLOT_W-1:0]  t_slot  [2];
  logic [PHASE_W-1:0] t_phase [2];
  logic [1:0]         hit, start_q;

  wire adv = tick_en && (pre_cnt >= presc);
  wire at_last = (phase == PH_LAST);

  wire [PHASE_W:0] ph_sum = {1'b0, phase} + {1'b0, off_ph};
  wire ph_carry = (ph_sum >= PH_MOD);

  assign master_phase = ph_carry ? PHASE_W'(ph_sum - PH_MOD) : ph_sum[PHASE_W-1:0];
  assign master_slot  = native_slot + off_slot + SLOT_W'(ph_carry);
  assign half_slot_strobe = adv && at_last;
  assign master_strobe    = adv && (master_phase == PH_LAST);
  assign tx_start = start_q[0];
  assign rx_start = start_q[1];

  always_comb
    for (int i = 0; i < 2; i++)
      hit[i] = task_en[i] && (master_slot == t_slot[i]) && (master_phase == t_phase[i]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt     <= '0;
      phase       <= '0;
      native_slot <= '0;
    end else if (tick_en) begin
      pre_cnt <= adv ? '0 : pre_cnt + 1'b1;
      if (adv) begin
        phase       <= at_last ? '0 : phase + 1'b1;
        native_slot <= native_slot + SLOT_W'(at_last);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_slot <= '0;
      off_ph   <= '0;
      task_en  <= '0;
      task_irq <= '0;
      start_q  <= '0;
      for (int i = 0; i < 2; i++) begin
        t_slot[i]  <= '0;
        t_phase[i] <= '0;
      end
    end else begin
      if (wr_en && wr_addr == 3'd0) off_slot <= wr_data[SLOT_W-1:0];
      if (wr_en && wr_addr == 3'd1 && wr_data <= 32'(PHASE_LAST)) off_ph <= wr_data[PHASE_W-1:0];
      for (int i = 0; i < 2; i++) begin
        if (wr_en && wr_addr == 3'(2 + 2*i)) t_slot[i] <= wr_data[SLOT_W-1:0];
        if (wr_en && wr_addr == 3'(3 + 2*i)) begin
          t_phase[i] <= wr_data[PHASE_W-1:0];
          task_en[i] <= wr_data[31];
        end
        if (wr_en && wr_addr == 3'd6 && wr_data[i]) task_irq[i] <= 1'b0;
        if (hit[i]) begin
          task_en[i]  <= 1'b0;
          task_irq[i] <= 1'b1;
        end
      end
      start_q <= hit;
    end
  end

endmodule

// File: rtl/bt_slot_timer_chk.sv
module bt_slot_timer_chk #(
  parameter int SLOT_W     = 28,
  parameter int PHASE_W    = 12,
  parameter int PHASE_LAST = 3749
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_en,
  input logic [PHASE_W-1:0] phase,
  input logic [SLOT_W-1:0]  native_slot,
  input logic [PHASE_W-1:0] master_phase,
  input logic               half_slot_strobe,
  input logic               tx_start,
  input logic               rx_start,
  input logic [1:0]         task_en,
  input logic [1:0]         task_irq
);

  localparam logic [PHASE_W-1:0] PH_LAST = PHASE_W'(PHASE_LAST);

  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PH_LAST);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(phase) && $stable(native_slot)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    half_slot_strobe |=> (phase == '0 && native_slot == $past(native_slot) + SLOT_W'(1)));

  p_master_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    master_phase <= PH_LAST);

  p_tx_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (!task_en[0] && task_irq[0]));

  p_rx_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |-> (!task_en[1] && task_irq[1]));

endmodule

bind bt_slot_timer bt_slot_timer_chk #(
  .SLOT_W(SLOT_W), .PHASE_W(PHASE_W), .PHASE_LAST(PHASE_LAST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .phase(phase),
  .native_slot(native_slot), .master_phase(master_phase),
  .half_slot_strobe(half_slot_strobe), .tx_start(tx_start),
  .rx_start(rx_start), .task_en(task_en), .task_irq(task_irq)
);

// File: tb/bt_slot_timer_test.sv
module bt_slot_timer_test;
  localparam int SW = 8, PW = 12, LAST = 99, PRW = 4;

  logic clk = 0, rst_n = 0, tick_en = 0, wr_en = 0;
  logic [PRW-1:0] presc = 0;
  logic [2:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [PW-1:0] phase, master_phase;
  logic [SW-1:0] native_slot, master_slot;
  logic half_slot_strobe, master_strobe, tx_start, rx_start;
  logic [1:0] task_en, task_irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bt_slot_timer #(.SLOT_W(SW), .PHASE_W(PW), .PHASE_LAST(LAST), .PRE_W(PRW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .presc(presc), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .phase(phase), .native_slot(native_slot),
    .master_phase(master_phase), .master_slot(master_slot),
    .half_slot_strobe(half_slot_strobe), .master_strobe(master_strobe),
    .tx_start(tx_start), .rx_start(rx_start), .task_en(task_en), .task_irq(task_irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(int n);
    @(negedge clk) tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk) begin wr_en = 1; wr_addr = a; wr_data = d; end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 phase", phase, 0);
    chk("R1 slot", native_slot, 0);
    chk("R1 master", {master_slot, master_phase}, 0);
    chk("R1 en/irq", {task_en, task_irq}, 0);
    chk("R1 strobes", {tx_start, rx_start, half_slot_strobe, master_strobe}, 0);
  endtask

  task automatic t_count;
    run(37);
    chk("R2 count", phase, 37);
    repeat (5) @(negedge clk);
    chk("R2 hold", phase, 37);
  endtask

  task automatic t_wrap;
    run(62);
    chk("R3 before wrap", {native_slot, phase}, {8'd0, 12'd99});
    @(negedge clk) tick_en = 1;
    #1 chk("R3 strobe", half_slot_strobe, 1);
    @(negedge clk) tick_en = 0;
    chk("R3 after wrap", {native_slot, phase}, {8'd1, 12'd0});
  endtask

  task automatic t_presc;
    presc = 2;
    run(9);
    chk("R2 prescale", phase, 3);
    presc = 0;
  endtask

  task automatic t_master;
    wr(0, 5);
    wr(1, 98);
    chk("R4 master phase", master_phase, 1);
    chk("R4 master slot", master_slot, 7);
    wr(1, 150);
    chk("R5 oversize offset ignored", master_phase, 1);
    wr(1, 96);
    chk("R5 offset load", master_phase, 99);
    @(negedge clk) tick_en = 1;
    #1 chk("R6 master strobe", {master_strobe, half_slot_strobe}, 2'b10);
    @(negedge clk) tick_en = 0;
    chk("R4 master after carry", {master_slot, master_phase}, {8'd7, 12'd0});
  endtask

  task automatic t_task(int i);
    int pulses = 0, others = 0;
    logic [PW-1:0] seen = 0;
    logic [PW-1:0] tgt = master_phase + 12'd10;
    wr(3'(2 + 2*i), 32'(master_slot));
    wr(3'(3 + 2*i), 32'h8000_0000 | 32'(tgt));
    chk("R7 armed", task_en[i], 1);
    @(negedge clk) tick_en = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if ((i == 0 ? tx_start : rx_start)) begin pulses++; seen = master_phase; end
      if ((i == 0 ? rx_start : tx_start)) others++;
    end
    tick_en = 0;
    chk("R7 one pulse", pulses, 1);
    chk("R7 pulse timing", seen, 32'(tgt) + 1);
    chk("R7 other start idle", others, 0);
    chk("R8 enable cleared", task_en[i], 0);
    repeat (5) @(negedge clk);
    chk("R8 irq sticky", task_irq[i], 1);
  endtask

  task automatic t_irqclr;
    wr(6, 1);
    chk("R9 clear task0", task_irq, 2'b10);
    wr(6, 2);
    chk("R9 clear task1", task_irq, 2'b00);
  endtask

  task automatic t_slotwrap;
    logic [SW+PW-1:0] start = {native_slot, phase};
    chk("R3 slot before", native_slot, 1);
    run(256 * 100);
    chk("R3 slot modulo wrap", {native_slot, phase}, start);
    wr(1, 0);
    wr(0, 255);
    chk("R4 master slot modulo", master_slot, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_count;
    t_wrap;
    t_presc;
    t_master;
    t_task(0);
    t_task(1);
    t_irqclr;
    t_slotwrap;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule